// File: doc/BRIEF.md
# Banked ROM/RAM Mapper Controller

This block sits between a CPU and the memories of a cartridge. The CPU cannot write to the lower half of its address space, which is read-only program memory. The mapper treats writes to that half as register updates instead. From these updates it keeps a switchable program bank, an external RAM bank, a RAM enable and a two-way banking mode.

The block drives the full program-memory address for the switchable 16 KiB window at 0x4000–0x7FFF. It also drives the external RAM address for the 8 KiB window at 0xA000–0xBFFF, and a chip-enable for that RAM. A static mask input gives the installed program-memory size minus one. Any bank beyond the fitted size therefore wraps back into it. The fixed lower window and the memories themselves live outside the block.

Top module: `bank_mapper`

## Requirements
- R1: After reset the program bank is 1, the RAM bank is 0, the mode is 0 and the RAM is disabled.
- R2: A write with address bits [15:13] = 0 sets the RAM enable on data 0x0A and clears it on data 0x00. Any other data leaves the enable unchanged.
- R3: A write with address bits [15:13] = 1 loads data bits [4:0] into program bank bits [4:0] and keeps bank bits [6:5].
- R4: If data bits [4:0] of such a write are zero, bank bits [4:0] become 1. Bank bits [4:0] are never zero.
- R5: In mode 0, a write with address bits [15:13] = 2 loads data bits [1:0] into program bank bits [6:5].
- R6: In mode 1, a write with address bits [15:13] = 2 loads data bits [1:0] into the RAM bank and leaves the program bank alone.
- R7: A write with address bits [15:13] = 3 sets the mode from data bit 0. Setting mode 1 clears program bank bits [6:5].
- R8: Setting mode 0 forces the RAM bank to 0.
- R9: The program address is masked with `rom_mask`, so a bank beyond the installed size wraps into it.
- R10: The program address is {bank, cpu_addr[13:0]}, before the mask.
- R11: The RAM address is {ram bank, cpu_addr[12:0]}. `ram_ce` is high only when the RAM is enabled and cpu_addr[15:13] = 5.
- R12: A cycle without `cpu_wr`, or a write with cpu_addr[15] = 1, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| rom_mask | input | 21 | Installed program-memory size minus one, in bytes |
| rom_addr | output | 21 | Program-memory byte address for the switchable window |
| ram_addr | output | 15 | External RAM byte address |
| ram_ce | output | 1 | External RAM chip-enable |

## Verification
The bench goes after the zero-bank promotion in two forms: a plain zero, and a value whose only set bits are above bit 4. A design that tested the whole byte would let bank 0x20 or 0x40 through. The bench switches modes both ways while the opposite bank bits hold non-zero values. A design that skipped the clearing would leave stale upper program bits in mode 1, or a stale RAM bank in mode 0. Region 2 writes are sent in both modes, so a design that ignored the mode would steer them into the wrong register. The bench also checks that enable values other than 0x00 and 0x0A are ignored, and that writes to the upper address half are ignored. It checks that a reduced ROM mask folds a high bank down, and that the RAM chip-enable stays low just outside its window.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
    localparam int ROM_BANK_W = 7;
    localparam int ROM_LO_W   = 5;
    localparam int ROM_HI_W   = ROM_BANK_W - ROM_LO_W;
    localparam int RAM_BANK_W = 2;
    localparam int ROM_OFS_W  = 14;
    localparam int RAM_OFS_W  = 13;
    localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W;
    localparam int RAM_ADDR_W = RAM_BANK_W + RAM_OFS_W;
    localparam int N_REGION   = 4;
    localparam logic [2:0] RAM_WINDOW = 3'b101;
    localparam logic [7:0] EN_ON  = 8'h0A;
    localparam logic [7:0] EN_OFF = 8'h00;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  mode;
        logic                  ram_en;
    } map_state_t;
endpackage

// File: rtl/bank_mapper_decode.sv
module bank_mapper_decode
    import bank_mapper_pkg::*;
(
    input  logic [15:0]         cpu_addr,
    input  logic                cpu_wr,
    output logic [N_REGION-1:0] strobe
);
    // One strobe per control region; the upper address half never selects one.
    for (genvar g = 0; g < N_REGION; g++) begin : g_region
        assign strobe[g] = cpu_wr && !cpu_addr[15] && (cpu_addr[14:13] == 2'(g));
    end
endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
    import bank_mapper_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_REGION-1:0] strobe,
    input  logic [7:0]          wdata,
    output map_state_t          state
);
    map_state_t s_d, s_q;
    logic [ROM_LO_W-1:0] lo_d;

    always_comb begin
        s_d  = s_q;
        lo_d = wdata[ROM_LO_W-1:0];
        if (lo_d == '0) begin
            lo_d = {{(ROM_LO_W-1){1'b0}}, 1'b1};
        end
        if (strobe[0]) begin
            if (wdata == EN_ON) begin
                s_d.ram_en = 1'b1;
            end else if (wdata == EN_OFF) begin
                s_d.ram_en = 1'b0;
            end
        end
        if (strobe[1]) begin
            s_d.rom_bank = {s_q.rom_bank[ROM_BANK_W-1:ROM_LO_W], lo_d};
        end
        if (strobe[2]) begin
            if (!s_q.mode) begin
                s_d.rom_bank[ROM_BANK_W-1:ROM_LO_W] = wdata[ROM_HI_W-1:0];
            end else begin
                s_d.ram_bank = wdata[RAM_BANK_W-1:0];
            end
        end
        if (strobe[3]) begin
            s_d.mode = wdata[0];
            if (wdata[0]) begin
                s_d.rom_bank[ROM_BANK_W-1:ROM_LO_W] = '0;
            end else begin
                s_d.ram_bank = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.rom_bank <= {{(ROM_BANK_W-1){1'b0}}, 1'b1};
            s_q.ram_bank <= '0;
            s_q.mode     <= 1'b0;
            s_q.ram_en   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign state = s_q;
endmodule

// File: rtl/bank_mapper_addr.sv
module bank_mapper_addr
    import bank_mapper_pkg::*;
(
    input  logic [15:0]           cpu_addr,
    input  logic [ROM_ADDR_W-1:0] rom_mask,
    input  map_state_t            state,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_ce
);
    logic [ROM_ADDR_W-1:0] raw_rom;

    always_comb begin
        raw_rom  = {state.rom_bank, cpu_addr[ROM_OFS_W-1:0]};
        rom_addr = raw_rom & rom_mask;
        ram_addr = {state.ram_bank, cpu_addr[RAM_OFS_W-1:0]};
        ram_ce   = state.ram_en && (cpu_addr[15:13] == RAM_WINDOW);
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    input  logic                  cpu_wr,
    input  logic [ROM_ADDR_W-1:0] rom_mask,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_ce
);
    logic [N_REGION-1:0] strobe;
    map_state_t          cur;

    bank_mapper_decode u_decode (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .strobe   (strobe)
    );

    bank_mapper_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .wdata  (cpu_wdata),
        .state  (cur)
    );

    bank_mapper_addr u_addr (
        .cpu_addr (cpu_addr),
        .rom_mask (rom_mask),
        .state    (cur),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr),
        .ram_ce   (ram_ce)
    );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import bank_mapper_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:0]           cpu_addr,
    input logic [7:0]            cpu_wdata,
    input logic                  cpu_wr,
    input logic [ROM_ADDR_W-1:0] rom_mask,
    input logic [ROM_ADDR_W-1:0] rom_addr,
    input logic                  ram_ce,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [RAM_BANK_W-1:0] ram_bank,
    input logic                  mode,
    input logic                  ram_en
);
    p_lo_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_bank[ROM_LO_W-1:0] != '0);

    p_lo_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'd1 && cpu_wdata[ROM_LO_W-1:0] != '0)
        |=> rom_bank[ROM_LO_W-1:0] == $past(cpu_wdata[ROM_LO_W-1:0]));

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata == EN_ON) |=> ram_en);

    p_hi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> rom_bank[ROM_BANK_W-1:ROM_LO_W] == '0);

    p_ram_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> ram_bank == '0);

    p_ce_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> (ram_en && cpu_addr[15:13] == RAM_WINDOW));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr & ~rom_mask) == '0);

    p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && !cpu_addr[15])
        |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(mode) && $stable(ram_en)));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .rom_mask  (rom_mask),
    .rom_addr  (rom_addr),
    .ram_ce    (ram_ce),
    .rom_bank  (cur.rom_bank),
    .ram_bank  (cur.ram_bank),
    .mode      (cur.mode),
    .ram_en    (cur.ram_en)
);

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        cpu_wr = 1'b0;
    logic [20:0] rom_mask = 21'h1FFFFF;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_ce;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_mapper dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .rom_mask  (rom_mask),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_ce    (ram_ce)
    );

    // {tag[3:0], wr_addr[15:0], wr_data[7:0], bank[6:0], ram_en, ram_bank[1:0]}
    localparam int NV = 15;
    localparam logic [37:0] VEC [NV] = '{
        {4'd2,  16'h0000, 8'h0A, 7'h01, 1'b1, 2'd0}, // R2 enable
        {4'd2,  16'h1FFF, 8'h55, 7'h01, 1'b1, 2'd0}, // R2 other value ignored
        {4'd3,  16'h2000, 8'h13, 7'h13, 1'b1, 2'd0}, // R3
        {4'd5,  16'h4000, 8'h02, 7'h53, 1'b1, 2'd0}, // R5
        {4'd4,  16'h2000, 8'h00, 7'h41, 1'b1, 2'd0}, // R4 zero
        {4'd4,  16'h3ABC, 8'hE0, 7'h41, 1'b1, 2'd0}, // R4 zero in low bits only
        {4'd3,  16'h2000, 8'h07, 7'h47, 1'b1, 2'd0}, // R3 keeps upper bits
        {4'd7,  16'h6000, 8'h01, 7'h07, 1'b1, 2'd0}, // R7 mode 1 clears upper
        {4'd6,  16'h5000, 8'h03, 7'h07, 1'b1, 2'd3}, // R6 ram bank
        {4'd3,  16'h2000, 8'h1F, 7'h1F, 1'b1, 2'd3}, // R3
        {4'd8,  16'h7FFF, 8'h00, 7'h1F, 1'b1, 2'd0}, // R8 mode 0 zeroes ram bank
        {4'd5,  16'h4000, 8'h01, 7'h3F, 1'b1, 2'd0}, // R5
        {4'd2,  16'h0000, 8'h00, 7'h3F, 1'b0, 2'd0}, // R2 disable
        {4'd12, 16'h8000, 8'h0A, 7'h3F, 1'b0, 2'd0}, // R12 upper half ignored
        {4'd12, 16'hE000, 8'h13, 7'h3F, 1'b0, 2'd0}  // R12 upper half ignored
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cpu_addr = 16'h4000; #1;
        chk("R1 rom_addr", 32'(rom_addr), 32'h04000);
        cpu_addr = 16'hA000; #1;
        chk("R1 ram_ce", 32'(ram_ce), 32'd0);
        chk("R1 ram_addr", 32'(ram_addr), 32'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            do_write(v[33:18], v[17:10]);
            cpu_addr = 16'h4123; #1;
            chk($sformatf("R%0d vec%0d rom_addr", v[37:34], i), 32'(rom_addr), 32'({v[9:3], 14'h0123}));
            cpu_addr = 16'hA456; #1;
            chk($sformatf("R%0d vec%0d ram_ce", v[37:34], i), 32'(ram_ce), 32'(v[2]));
            chk($sformatf("R%0d vec%0d ram_addr", v[37:34], i), 32'(ram_addr), 32'({v[1:0], 13'h0456}));
        end

        // R12: region-1 data presented without the strobe
        @(negedge clk);
        cpu_addr = 16'h2000; cpu_wdata = 8'h05; cpu_wr = 1'b0;
        @(negedge clk);
        cpu_addr = 16'h4123; #1;
        chk("R12 no strobe", 32'(rom_addr), 32'({7'h3F, 14'h0123}));

        // R10 window edge
        cpu_addr = 16'h7FFF; #1;
        chk("R10 top of window", 32'(rom_addr), 32'h0FFFFF);

        // R9 wrap with a 256 KiB device
        rom_mask = 21'h03FFFF;
        cpu_addr = 16'h4123; #1;
        chk("R9 wrap", 32'(rom_addr), 32'({7'h0F, 14'h0123}));
        rom_mask = 21'h1FFFFF;

        // R11 chip enable only inside its window
        do_write(16'h0000, 8'h0A);
        cpu_addr = 16'hBFFF; #1;
        chk("R11 ce inside", 32'(ram_ce), 32'd1);
        cpu_addr = 16'hC000; #1;
        chk("R11 ce above", 32'(ram_ce), 32'd0);
        cpu_addr = 16'h9FFF; #1;
        chk("R11 ce below", 32'(ram_ce), 32'd0);

        // R6 then R8 with ram bank 2, seen on the RAM address
        do_write(16'h6000, 8'h01);
        do_write(16'h4000, 8'h02);
        cpu_addr = 16'hA001; #1;
        chk("R6 ram_addr", 32'(ram_addr), 32'h4001);
        do_write(16'h6000, 8'h00);
        cpu_addr = 16'hA001; #1;
        chk("R8 ram_addr", 32'(ram_addr), 32'h0001);

        // R1 again after a second reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cpu_addr = 16'h4000; #1;
        chk("R1 re-reset rom", 32'(rom_addr), 32'h04000);
        cpu_addr = 16'hA000; #1;
        chk("R1 re-reset ce", 32'(ram_ce), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule